// File: doc/BRIEF.md
# Four-Slot One-Time-Programmable Write Manager

This block owns a small write-once store made of four 10-bit slots and everything needed to fill it safely. A command decoder hands it a write request carrying a code. When a slot is still free and no programming is in progress, the block raises a supply-enable phase, then a program strobe, and finally commits the code into the next free slot. Slots fill strictly from 0 up to 3. Once the last slot holds a value, the store is locked and no further request is accepted.

The block also holds the code driven to the DAC. After a power-on or a soft (general-call) reset, that code is the most recently committed slot, or midscale when no slot is filled. An acquire request loads the same latest slot, but falls back to zero when the store is empty. A completed write also loads its own code onto the DAC. Used slots are reported as a thermometer count. Slot contents survive the soft reset and are cleared only by the power-on reset `rst_n`.

The controller is one state machine with three states:
- `ST_IDLE`: waiting.
- `ST_SUPPLY`: supply enabled, strobe low.
- `ST_STROBE`: supply enabled and strobe high.

Its transitions are:
- `ST_IDLE` to `ST_SUPPLY`: an accepted request, meaning not full and no soft reset.
- `ST_SUPPLY` to `ST_STROBE`: after `SETUP_CYC` cycles.
- `ST_STROBE` to `ST_IDLE`: after `STROBE_CYC` cycles, with the commit happening on that last cycle.
- `ST_SUPPLY` or `ST_STROBE` to `ST_IDLE`: a soft reset, which aborts the sequence and commits nothing.

The defaults of 200 and 2000 cycles correspond to 20 µs and 200 µs at a 10 MHz clock.

Top module: `otp_slot_mgr`

## Requirements
- R1: Only four writes are ever committed. With all four slots used, a write request is ignored: `supply_en_o` and `busy_o` stay 0, `status_o` stays 4'b1111, and `dac_code_o` is unchanged.
- R2: `status_o` is a thermometer of used slots, where bit i = 1 means slot i is written. After 0 to 4 commits it reads 4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111 in turn.
- R3: Slots fill in order 0 to 3, and the value used for reset and acquire is always the one from the most recent commit.
- R4: While `rst_n` is low, all slots are cleared: `status_o` = 0, `busy_o` = 0, `supply_en_o` = 0, `strobe_o` = 0, and `dac_code_o` = 10'h200 (binary 1000000000).
- R5: A one-cycle `gc_reset_i` sets `dac_code_o` at the next edge to the latest slot value, or to 10'h200 if no slot is written. It keeps the slot contents. It aborts a sequence in progress, so no slot is written and `busy_o` drops at that edge.
- R6: A one-cycle `acquire_i` sets `dac_code_o` at the next edge to the latest slot value, or to 10'h000 if no slot is written. A soft reset in the same cycle takes precedence.
- R7: An accepted request raises `supply_en_o` at the capturing edge. `strobe_o` rises exactly `SETUP_CYC` cycles later and stays high for exactly `STROBE_CYC` cycles. `supply_en_o` and `strobe_o` then fall together.
- R8: `busy_o` is high from the accepting edge until the sequence ends. A request arriving while busy is dropped and never produces a second commit.
- R9: At the edge that ends the strobe, the requested code is stored in the next free slot and also appears on `dac_code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset; clears slots |
| gc_reset_i | input | 1 | Soft reset pulse from a general call |
| acquire_i | input | 1 | Load latest slot value onto the DAC code |
| wr_req_i | input | 1 | Request to program `wr_data_i` into the next slot |
| wr_data_i | input | 10 | Code to program |
| busy_o | output | 1 | Programming sequence in progress |
| supply_en_o | output | 1 | Program supply enable |
| strobe_o | output | 1 | Program write strobe |
| status_o | output | 4 | Thermometer count of used slots |
| dac_code_o | output | 10 | Code driven to the DAC |

## Verification
The bench measures the supply lead time and the strobe width cycle by cycle. An off-by-one counter would report 199 or 2001 instead of the parameter values. It injects a second request in the middle of a strobe; a design that queues it would show an extra status bit. It aborts a sequence with a soft reset, where a leaky design would commit the aborted code or leave `busy_o` high. It also compares the empty-store defaults of soft reset (midscale) and acquire (zero), which a design sharing one default would get wrong. Finally, it sends a fifth request against a full store, where a design without lockout would raise the supply or change the DAC code.

// File: rtl/otp_mgr_pkg.sv
package otp_mgr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SUPPLY = 2'd1,
        ST_STROBE = 2'd2
    } prog_state_e;
endpackage

// File: rtl/otp_slot_bank.sv
module otp_slot_bank #(
    parameter int NSLOTS = 4,
    parameter int W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [W-1:0]      commit_data,
    output logic [NSLOTS-1:0] used,
    output logic              full,
    output logic              any,
    output logic [W-1:0]      latest
);
    logic [NSLOTS-1:0] sel;
    logic [W-1:0]      vals [NSLOTS];

    for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
        logic         v_q;
        logic [W-1:0] d_q;
        if (i == 0) begin : g_first
            assign sel[i] = !v_q;
        end else begin : g_rest
            assign sel[i] = used[i-1] && !v_q;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (commit && sel[i]) begin
                v_q <= 1'b1;
                d_q <= commit_data;
            end
        end
        assign used[i] = v_q;
        assign vals[i] = d_q;
    end

    always_comb begin
        latest = '0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (used[i]) latest = vals[i];
        end
    end

    assign full = used[NSLOTS-1];
    assign any  = used[0];

    AST_THERMO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((used + 1'b1) & used) == '0); // R2
    AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> ($stable(used) && $stable(latest))); // R1
    AST_NO_COMMIT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(used)); // R3
endmodule

// File: rtl/otp_prog_fsm.sv
module otp_prog_fsm
    import otp_mgr_pkg::*;
#(
    parameter int W          = 10,
    parameter int SETUP_CYC  = 200,
    parameter int STROBE_CYC = 2000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    input  logic         full,
    output logic         busy,
    output logic         supply_en,
    output logic         strobe,
    output logic         commit,
    output logic [W-1:0] commit_data
);
    localparam int MAXC = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    prog_state_e   state, nxt;
    logic [CW-1:0] cnt;
    logic [W-1:0]  data_q;
    logic          last_strobe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            data_q <= '0;
        end else begin
            state <= nxt;
            if (state != nxt || nxt == ST_IDLE) cnt <= '0;
            else                                cnt <= cnt + 1'b1;
            if (state == ST_IDLE && nxt == ST_SUPPLY) data_q <= wr_data;
        end
    end

    assign last_strobe = (cnt == CW'(STROBE_CYC - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!soft_rst && wr_req && !full) nxt = ST_SUPPLY;
            ST_SUPPLY: if (soft_rst) nxt = ST_IDLE;
                       else if (cnt == CW'(SETUP_CYC - 1)) nxt = ST_STROBE;
            ST_STROBE: if (soft_rst || last_strobe) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = 1'b0; supply_en = 1'b0; strobe = 1'b0; commit = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SUPPLY: begin busy = 1'b1; supply_en = 1'b1; end
            ST_STROBE: begin
                busy = 1'b1; supply_en = 1'b1; strobe = 1'b1;
                commit = last_strobe && !soft_rst;
            end
            default: ;
        endcase
    end
    assign commit_data = data_q;

    int lead_q, str_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q <= 0;
            str_q  <= 0;
        end else begin
            lead_q <= !supply_en ? 0 : (strobe ? lead_q : lead_q + 1);
            str_q  <= strobe ? str_q + 1 : 0;
        end
    end

    AST_SUPPLY_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> (lead_q == SETUP_CYC)); // R7
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (str_q == STROBE_CYC - 1)); // R7
    AST_LOCKOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && full) |=> (state == ST_IDLE)); // R1
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !soft_rst && !commit) |=> busy); // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !busy); // R5
endmodule

// File: rtl/otp_slot_mgr.sv
module otp_slot_mgr #(
    parameter int W          = 10,
    parameter int NSLOTS     = 4,
    parameter int SETUP_CYC  = 200,
    parameter int STROBE_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gc_reset_i,
    input  logic              acquire_i,
    input  logic              wr_req_i,
    input  logic [W-1:0]      wr_data_i,
    output logic              busy_o,
    output logic              supply_en_o,
    output logic              strobe_o,
    output logic [NSLOTS-1:0] status_o,
    output logic [W-1:0]      dac_code_o
);
    localparam logic [W-1:0] MIDSCALE = {1'b1, {(W-1){1'b0}}};

    logic         commit, full, any;
    logic [W-1:0] commit_data, latest;

    otp_prog_fsm #(.W(W), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(gc_reset_i),
        .wr_req(wr_req_i), .wr_data(wr_data_i), .full(full),
        .busy(busy_o), .supply_en(supply_en_o), .strobe(strobe_o),
        .commit(commit), .commit_data(commit_data)
    );

    otp_slot_bank #(.NSLOTS(NSLOTS), .W(W)) u_bank (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_data(commit_data),
        .used(status_o), .full(full), .any(any), .latest(latest)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)          dac_code_o <= MIDSCALE;
        else if (gc_reset_i) dac_code_o <= any ? latest : MIDSCALE;
        else if (commit)     dac_code_o <= commit_data;
        else if (acquire_i)  dac_code_o <= any ? latest : '0;
    end

    AST_ACQ_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acquire_i && !gc_reset_i && !busy_o && status_o == '0) |=> (dac_code_o == '0)); // R6
    AST_GC_EMPTY_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (gc_reset_i && status_o == '0) |=> (dac_code_o == MIDSCALE)); // R5
    AST_COMMIT_LOADS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (dac_code_o == $past(commit_data))); // R9
endmodule

// File: tb/test_otp_slot_mgr.sv
module test_otp_slot_mgr;
    localparam int CLK_PERIOD = 10;
    localparam int SETUP      = 200;
    localparam int STROBE     = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gc_reset_i = 1'b0, acquire_i = 1'b0, wr_req_i = 1'b0;
    logic [9:0] wr_data_i = '0;
    logic       busy_o, supply_en_o, strobe_o;
    logic [3:0] status_o;
    logic [9:0] dac_code_o;

    int n_chk = 0, n_fail = 0, cyc = 0;

    otp_slot_mgr i_otp_slot_mgr (
        .clk(clk), .rst_n(rst_n), .gc_reset_i(gc_reset_i), .acquire_i(acquire_i),
        .wr_req_i(wr_req_i), .wr_data_i(wr_data_i), .busy_o(busy_o),
        .supply_en_o(supply_en_o), .strobe_o(strobe_o), .status_o(status_o),
        .dac_code_o(dac_code_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 60000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_gc();
        @(negedge clk) gc_reset_i = 1'b1;
        @(negedge clk) gc_reset_i = 1'b0;
    endtask

    task automatic pulse_acq();
        @(negedge clk) acquire_i = 1'b1;
        @(negedge clk) acquire_i = 1'b0;
    endtask

    task automatic t_power_on();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 status", status_o, 0);
        chk("R4 dac midscale", dac_code_o, 10'h200);
        chk("R4 busy", busy_o, 0);
        chk("R4 supply/strobe", {supply_en_o, strobe_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_empty_defaults();
        pulse_acq();
        chk("R6 acquire empty -> 0", dac_code_o, 10'h000);
        pulse_gc();
        chk("R5 gc empty -> midscale", dac_code_o, 10'h200);
    endtask

    task automatic t_program(input logic [9:0] v, input bit inject, input int exp_status);
        int lead = 0, slen = 0;
        @(negedge clk) begin wr_req_i = 1'b1; wr_data_i = v; end
        @(negedge clk) wr_req_i = 1'b0;
        chk("R8 busy after accept", busy_o, 1);
        while (supply_en_o && !strobe_o && lead < 5000) begin
            lead++;
            @(negedge clk);
        end
        chk("R7 supply lead cycles", lead, SETUP);
        while (strobe_o && slen < 5000) begin
            if (inject && slen == 5) begin wr_req_i = 1'b1; wr_data_i = 10'h0F0; end
            if (inject && slen == 6) wr_req_i = 1'b0;
            slen++;
            @(negedge clk);
        end
        chk("R7 strobe width cycles", slen, STROBE);
        chk("R7 supply falls with strobe", supply_en_o, 0);
        chk("R8 busy cleared", busy_o, 0);
        chk("R2 status thermometer", status_o, exp_status);
        chk("R9 dac takes written code", dac_code_o, v);
        repeat (3) @(negedge clk);
        chk("R8 no extra commit", status_o, exp_status);
    endtask

    task automatic t_abort(input int exp_status, input logic [9:0] exp_dac);
        @(negedge clk) begin wr_req_i = 1'b1; wr_data_i = 10'h0AA; end
        @(negedge clk) wr_req_i = 1'b0;
        repeat (SETUP + 50) @(negedge clk);
        chk("R5 strobe active before abort", strobe_o, 1);
        pulse_gc();
        chk("R5 abort clears busy", busy_o, 0);
        chk("R5 abort drops supply", supply_en_o, 0);
        chk("R5 gc loads latest", dac_code_o, exp_dac);
        repeat (STROBE + 10) @(negedge clk);
        chk("R5 abort writes no slot", status_o, exp_status);
    endtask

    task automatic t_lockout(input logic [9:0] exp_dac);
        @(negedge clk) begin wr_req_i = 1'b1; wr_data_i = 10'h111; end
        @(negedge clk) wr_req_i = 1'b0;
        chk("R1 full: no supply", supply_en_o, 0);
        chk("R1 full: not busy", busy_o, 0);
        repeat (SETUP + STROBE + 20) @(negedge clk);
        chk("R1 full: status", status_o, 4'b1111);
        chk("R1 full: dac unchanged", dac_code_o, exp_dac);
        pulse_acq();
        chk("R3 acquire gives last slot", dac_code_o, exp_dac);
        pulse_gc();
        chk("R3 gc gives last slot", dac_code_o, exp_dac);
    endtask

    initial begin
        t_power_on();
        t_empty_defaults();
        t_program(10'h155, 1'b1, 4'b0001);
        pulse_gc();
        chk("R5 gc keeps slot", dac_code_o, 10'h155);
        chk("R5 slots persist", status_o, 4'b0001);
        t_abort(4'b0001, 10'h155);
        t_program(10'h3FF, 1'b0, 4'b0011);
        t_program(10'h001, 1'b0, 4'b0111);
        pulse_acq();
        chk("R6 acquire latest", dac_code_o, 10'h001);
        t_program(10'h2C3, 1'b0, 4'b1111);
        t_lockout(10'h2C3);
        t_power_on();
        pulse_acq();
        chk("R4 slots cleared, acquire -> 0", dac_code_o, 10'h000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule